// File: doc/BRIEF.md
# Spread-spectrum profile generator

This block produces the digital frequency-offset profile that a spread-spectrum clock synthesizer applies to its output. A 4-bit select code picks two things at once: the peak deviation, and the divisor that sets how fast the profile repeats. The output is a signed triangle that starts at the negative peak, rises linearly to the positive peak, and then falls back. One full triangle takes a number of reference-clock cycles equal to the selected divisor.

The offset word is signed fixed point. Its integer unit is 0.25 percent of nominal frequency, and it has eight fractional bits, so a raw value of 256 means +0.25 %. The block applies a nonzero code change only at the negative peak, so the waveform stays continuous while it runs. Code zero stops the spreading at once and holds the offset at zero. A separate flag reports whether spreading is requested.

Top module: `ssm_profile_gen`

## Requirements
- R1: While the sampled select code is 0, the offset output is 0 from the next clock edge on. It is also 0 during and right after reset.
- R2: `ss_active` is high exactly when `ss_code` is nonzero, with no clock delay.
- R3: For a code c from 1 to 15, let d = (c-1) mod 4. The peak is 2·(d+1) quarter-percent units (±0.5, ±1.0, ±1.5, ±2.0 %), which is a raw value of 512·(d+1). The raw output reaches +512·(d+1) at the start of the falling half.
- R4: For a code c from 1 to 15, let g = (c-1) div 4. The period is D = 620, 370, 258 and 192 cycles for g = 0, 1, 2 and 3. The offset returns to the negative peak every D cycles.
- R5: On the first clock edge that samples a nonzero code after code 0 or after reset, the output loads the negative peak of that code.
- R6: The rising half lasts R = ceil(D/2) cycles. At cycle k of that half (k = 0 … R-1), the raw output is −p + floor(2p·k/R), where p is the raw peak.
- R7: The falling half lasts F = floor(D/2) cycles. At cycle j of that half (j = 0 … F-1), the raw output is p − floor(2p·j/F).
- R8: A change between nonzero codes takes effect only when the period wraps to the negative peak. If the code changes several times within one period, the code present at the wrap is the one used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ss_code | input | 4 | Select code. 0 turns spreading off; 1–15 pick the peak and the divisor |
| ss_offset | output | 13 | Signed offset, unit 0.25 %, 8 fractional bits |
| ss_active | output | 1 | High when the select code is nonzero |

## Verification
A phase counter that is off by one shows up as a peak landing one cycle early or late. That is visible at the output within one half period, at most 310 cycles. A remainder accumulator that skips or doubles a carry moves the output by one raw LSB at the next carry, usually within a few cycles. A configuration register that loads at the wrong moment shows up as a jump in the slope or the peak in the middle of a ramp, right after the code changes. A missed clear shows up as a nonzero output on the cycle after code 0 is sampled.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   // Per-cycle command from the phase sequencer to the ramp datapath
   typedef enum logic [1:0] {
      RAMP_CLEAR = 2'd0,
      RAMP_LOAD  = 2'd1,
      RAMP_STEP  = 2'd2
   } ramp_ctl_e;

   // Peak deviation in integer offset units for a deviation index
   function automatic int peak_units(input int unit, input int dev_idx);
      return unit * (dev_idx + 1);
   endfunction

endpackage

// File: rtl/ssm_cfg_lookup.sv
module ssm_cfg_lookup #(
   parameter int DEV_W   = 2,
   parameter int GRP_W   = 2,
   parameter int FRAC_W  = 8,
   parameter int UNIT    = 2,
   parameter int OFS_W   = 13,
   parameter int PHASE_W = 9,
   parameter int unsigned DIV_TAB [2**GRP_W] = '{620, 370, 258, 192}
)(
   input  logic [DEV_W-1:0]         dev,
   input  logic [GRP_W-1:0]         grp,
   output logic [PHASE_W-1:0]       rise_len,
   output logic [PHASE_W-1:0]       fall_len,
   output logic signed [OFS_W-1:0]  rise_q,
   output logic [PHASE_W-1:0]       rise_r,
   output logic signed [OFS_W-1:0]  fall_q,
   output logic [PHASE_W-1:0]       fall_r
);

   localparam int NDEV = 2**DEV_W;
   localparam int NGRP = 2**GRP_W;
   localparam int NENT = NDEV * NGRP;

   logic [PHASE_W-1:0]      rl_tab [NGRP];
   logic [PHASE_W-1:0]      fl_tab [NGRP];
   logic signed [OFS_W-1:0] rq_tab [NENT];
   logic [PHASE_W-1:0]      rr_tab [NENT];
   logic signed [OFS_W-1:0] fq_tab [NENT];
   logic [PHASE_W-1:0]      fr_tab [NENT];

   // Half lengths per divisor group; the odd cycle goes to the rising half
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int unsigned DV = DIV_TAB[g];
      localparam int unsigned RL = (DV + 1) / 2;
      localparam int unsigned FL = DV / 2;

      assign rl_tab[g] = PHASE_W'(RL);
      assign fl_tab[g] = PHASE_W'(FL);

      // Per-step quotient and remainder of the full swing over each half
      for (genvar d = 0; d < NDEV; d++) begin : g_dev
         localparam int unsigned SWING = 2 * UNIT * (d + 1) * (2**FRAC_W);
         localparam int          E     = g * NDEV + d;

         assign rq_tab[E] = OFS_W'(SWING / RL);
         assign rr_tab[E] = PHASE_W'(SWING % RL);
         assign fq_tab[E] = OFS_W'(SWING / FL);
         assign fr_tab[E] = PHASE_W'(SWING % FL);
      end
   end

   logic [GRP_W+DEV_W-1:0] ent;
   assign ent = {grp, dev};

   assign rise_len = rl_tab[grp];
   assign fall_len = fl_tab[grp];
   assign rise_q   = rq_tab[ent];
   assign rise_r   = rr_tab[ent];
   assign fall_q   = fq_tab[ent];
   assign fall_r   = fr_tab[ent];

endmodule

// File: rtl/ssm_phase_seq.sv
module ssm_phase_seq
   import ssm_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int DEV_W   = 2,
   parameter int PHASE_W = 9
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CODE_W-1:0]         code,
   input  logic [PHASE_W-1:0]        rise_len,
   input  logic [PHASE_W-1:0]        fall_len,
   output logic                      run,
   output logic                      falling,
   output logic [DEV_W-1:0]          cfg_dev,
   output logic [CODE_W-DEV_W-1:0]   cfg_grp,
   output logic [DEV_W-1:0]          new_dev,
   output ramp_ctl_e                 ctl
);

   localparam int GRP_W = CODE_W - DEV_W;

   logic [PHASE_W-1:0] pos;
   logic [CODE_W-1:0]  idx;
   logic [GRP_W-1:0]   new_grp;
   logic               code_on;
   logic               last_rise;
   logic               last_fall;

   assign code_on = |code;
   assign idx     = code - CODE_W'(1);
   assign new_dev = idx[DEV_W-1:0];
   assign new_grp = idx[CODE_W-1:DEV_W];

   assign last_rise = run && !falling && (pos == rise_len - PHASE_W'(1));
   assign last_fall = run &&  falling && (pos == fall_len - PHASE_W'(1));

   // Code zero wins; a start or a wrap reloads the configuration
   always_comb begin
      if (!code_on)
         ctl = RAMP_CLEAR;
      else if (!run || last_fall)
         ctl = RAMP_LOAD;
      else
         ctl = RAMP_STEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         falling <= 1'b0;
         pos     <= '0;
         cfg_dev <= '0;
         cfg_grp <= '0;
      end else begin
         unique case (ctl)
            RAMP_CLEAR: begin
               run     <= 1'b0;
               falling <= 1'b0;
               pos     <= '0;
            end
            RAMP_LOAD: begin
               run     <= 1'b1;
               falling <= 1'b0;
               pos     <= '0;
               cfg_dev <= new_dev;
               cfg_grp <= new_grp;
            end
            default: begin
               if (last_rise) begin
                  falling <= 1'b1;
                  pos     <= '0;
               end else begin
                  pos <= pos + PHASE_W'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/ssm_ramp_dda.sv
module ssm_ramp_dda
   import ssm_pkg::*;
#(
   parameter int OFS_W   = 13,
   parameter int PHASE_W = 9
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  ramp_ctl_e                ctl,
   input  logic                     dir_down,
   input  logic signed [OFS_W-1:0]  load_val,
   input  logic signed [OFS_W-1:0]  step_q,
   input  logic [PHASE_W-1:0]       step_r,
   input  logic [PHASE_W-1:0]       den,
   output logic signed [OFS_W-1:0]  acc
);

   logic [PHASE_W-1:0]      rem;
   logic [PHASE_W:0]        rem_sum;
   logic [PHASE_W:0]        rem_wrap;
   logic                    carry;
   logic signed [OFS_W-1:0] delta;

   // Exact division by the half length: quotient every step, carry from remainder
   always_comb begin
      rem_sum  = {1'b0, rem} + {1'b0, step_r};
      carry    = (rem_sum >= {1'b0, den});
      rem_wrap = carry ? (rem_sum - {1'b0, den}) : rem_sum;
      delta    = step_q + (carry ? OFS_W'(1) : OFS_W'(0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         rem <= '0;
      end else begin
         unique case (ctl)
            RAMP_CLEAR: begin
               acc <= '0;
               rem <= '0;
            end
            RAMP_LOAD: begin
               acc <= load_val;
               rem <= '0;
            end
            default: begin
               acc <= dir_down ? (acc - delta) : (acc + delta);
               rem <= rem_wrap[PHASE_W-1:0];
            end
         endcase
      end
   end

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
   import ssm_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter int DEV_W  = 2,
   parameter int FRAC_W = 8,
   parameter int UNIT   = 2,
   parameter int unsigned DIV_TAB [2**(CODE_W-DEV_W)] = '{620, 370, 258, 192}
)(
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic [CODE_W-1:0]                                 ss_code,
   output logic signed [FRAC_W+$clog2(UNIT*(2**DEV_W)+1):0]  ss_offset,
   output logic                                              ss_active
);

   localparam int GRP_W        = CODE_W - DEV_W;
   localparam int NGRP         = 2**GRP_W;
   localparam int NDEV         = 2**DEV_W;
   localparam int PEAK_MAX     = UNIT * NDEV;
   localparam int INT_W        = $clog2(PEAK_MAX + 1) + 1;
   localparam int OFS_W        = INT_W + FRAC_W;
   localparam int PEAK_RAW_MAX = PEAK_MAX * (2**FRAC_W);

   function automatic int unsigned widest_div();
      int unsigned m = 0;
      for (int i = 0; i < NGRP; i++)
         if (DIV_TAB[i] > m) m = DIV_TAB[i];
      return m;
   endfunction

   localparam int unsigned MAX_RISE = (widest_div() + 1) / 2;
   localparam int          PHASE_W  = $clog2(MAX_RISE + 1);

   // Elaboration-time parameter checks
   if (FRAC_W < 8) begin : g_bad_frac
      $error("ssm_profile_gen: FRAC_W must be at least 8");
   end
   if (DEV_W < 1 || DEV_W >= CODE_W) begin : g_bad_split
      $error("ssm_profile_gen: DEV_W must leave at least one group bit");
   end
   if (UNIT < 1) begin : g_bad_unit
      $error("ssm_profile_gen: UNIT must be positive");
   end
   if (2 * UNIT * (2**FRAC_W) < MAX_RISE) begin : g_bad_slope
      $error("ssm_profile_gen: smallest slope would fall below one LSB per cycle");
   end
   for (genvar g = 0; g < NGRP; g++) begin : g_div_chk
      if (DIV_TAB[g] < 2) begin : g_bad_div
         $error("ssm_profile_gen: every divisor must be at least 2");
      end
   end

   logic                    seq_run;
   logic                    seq_falling;
   logic [DEV_W-1:0]        cfg_dev;
   logic [GRP_W-1:0]        cfg_grp;
   logic [DEV_W-1:0]        new_dev;
   ramp_ctl_e               ctl;

   logic [PHASE_W-1:0]      rise_len;
   logic [PHASE_W-1:0]      fall_len;
   logic signed [OFS_W-1:0] rise_q;
   logic [PHASE_W-1:0]      rise_r;
   logic signed [OFS_W-1:0] fall_q;
   logic [PHASE_W-1:0]      fall_r;

   logic signed [OFS_W-1:0] step_q;
   logic [PHASE_W-1:0]      step_r;
   logic [PHASE_W-1:0]      den;
   logic signed [OFS_W-1:0] load_val;
   logic signed [OFS_W-1:0] acc;

   ssm_phase_seq #(
      .CODE_W  (CODE_W),
      .DEV_W   (DEV_W),
      .PHASE_W (PHASE_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (ss_code),
      .rise_len (rise_len),
      .fall_len (fall_len),
      .run      (seq_run),
      .falling  (seq_falling),
      .cfg_dev  (cfg_dev),
      .cfg_grp  (cfg_grp),
      .new_dev  (new_dev),
      .ctl      (ctl)
   );

   ssm_cfg_lookup #(
      .DEV_W   (DEV_W),
      .GRP_W   (GRP_W),
      .FRAC_W  (FRAC_W),
      .UNIT    (UNIT),
      .OFS_W   (OFS_W),
      .PHASE_W (PHASE_W),
      .DIV_TAB (DIV_TAB)
   ) u_lookup (
      .dev      (cfg_dev),
      .grp      (cfg_grp),
      .rise_len (rise_len),
      .fall_len (fall_len),
      .rise_q   (rise_q),
      .rise_r   (rise_r),
      .fall_q   (fall_q),
      .fall_r   (fall_r)
   );

   // Direction select for the stepping datapath
   assign step_q = seq_falling ? fall_q   : rise_q;
   assign step_r = seq_falling ? fall_r   : rise_r;
   assign den    = seq_falling ? fall_len : rise_len;

   // Negative peak of the incoming code, used on start and on wrap
   always_comb begin
      load_val = OFS_W'(-(peak_units(UNIT, int'(new_dev)) * (2**FRAC_W)));
   end

   ssm_ramp_dda #(
      .OFS_W   (OFS_W),
      .PHASE_W (PHASE_W)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .dir_down (seq_falling),
      .load_val (load_val),
      .step_q   (step_q),
      .step_r   (step_r),
      .den      (den),
      .acc      (acc)
   );

   assign ss_offset = acc;
   assign ss_active = |ss_code;

endmodule

module ssm_profile_chk #(
   parameter int OFS_W        = 13,
   parameter int CODE_W       = 4,
   parameter int CFG_W        = 4,
   parameter int PEAK_RAW_MAX = 2048
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic [CODE_W-1:0]       code,
   input logic signed [OFS_W-1:0] offset,
   input logic                    active,
   input logic                    run,
   input logic                    falling,
   input logic [CFG_W-1:0]        cfg
);

   // R1: a sampled code of zero leaves a zero offset one edge later
   a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0) |=> (offset == '0));

   // R3: the offset never leaves the largest selectable peak
   a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(offset) <= PEAK_RAW_MAX) && (int'(offset) >= -PEAK_RAW_MAX));

   // R5: turning spreading on starts from a negative offset
   a_r5_start_trough: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |=> (offset < 0));

   // R6: inside the rising half every step moves strictly up
   a_r6_rise_up: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !falling && $past(run && !falling)) |-> (offset > $past(offset)));

   // R7: inside the falling half every step moves strictly down
   a_r7_fall_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && falling && $past(run && falling)) |-> (offset < $past(offset)));

   // R8: a running configuration only changes at the negative peak
   a_r8_cfg_at_trough: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(cfg)) |-> (!falling && offset < 0));

endmodule

bind ssm_profile_gen ssm_profile_chk #(
   .OFS_W        (OFS_W),
   .CODE_W       (CODE_W),
   .CFG_W        (CODE_W),
   .PEAK_RAW_MAX (PEAK_RAW_MAX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .code    (ss_code),
   .offset  (ss_offset),
   .active  (ss_active),
   .run     (seq_run),
   .falling (seq_falling),
   .cfg     ({cfg_grp, cfg_dev})
);

// File: tb/ssm_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssm_profile_gen_tb_top;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [3:0]         code_drv = 4'd0;
   logic signed [12:0] ofs;
   logic               act;

   int n_checks = 0;
   int n_errs   = 0;

   // Reference model state
   int m_on   = 0;
   int m_cfg  = 0;
   int m_t    = 0;
   int m_hint = 0;   // 0 plain, 1 fresh start, 2 code swapped at wrap

   ssm_profile_gen dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ss_code   (code_drv),
      .ss_offset (ofs),
      .ss_active (act)
   );

   always #10 clk = ~clk;

   function automatic int div_of(input int c);
      case ((c - 1) / 4)
         0:       return 620;
         1:       return 370;
         2:       return 258;
         default: return 192;
      endcase
   endfunction

   function automatic int peak_raw(input int c);
      return 2 * (((c - 1) % 4) + 1) * 256;
   endfunction

   function automatic int ramp(input int c, input int t);
      int p  = peak_raw(c);
      int d  = div_of(c);
      int rl = (d + 1) / 2;
      int fl = d / 2;
      if (t < rl) return -p + (2 * p * t) / rl;
      return p - (2 * p * (t - rl)) / fl;
   endfunction

   task automatic chk(input string tag, input int got, input int exp_v);
      n_checks++;
      if (got != exp_v) begin
         n_errs++;
         $display("FAIL %s: actual %0d expected %0d (code %0d phase %0d)",
                  tag, got, exp_v, code_drv, m_t);
      end
   endtask

   // Advance the model by one clock edge with the code driven at that edge
   task automatic model_step();
      int c = int'(code_drv);
      m_hint = 0;
      if (c == 0) begin
         m_on = 0;
         m_t  = 0;
      end else if (m_on == 0) begin
         m_on   = 1;
         m_cfg  = c;
         m_t    = 0;
         m_hint = 1;
      end else begin
         m_t++;
         if (m_t == div_of(m_cfg)) begin
            m_t = 0;
            if (c != m_cfg) m_hint = 2;
            m_cfg = c;
         end
      end
   endtask

   task automatic check_now();
      int rl;
      chk("R2", int'(act), (code_drv != 4'd0) ? 1 : 0);
      if (m_on == 0) begin
         chk("R1", int'(ofs), 0);
      end else begin
         rl = (div_of(m_cfg) + 1) / 2;
         if (m_hint == 1)       chk("R5", int'(ofs), ramp(m_cfg, m_t));
         else if (m_hint == 2)  chk("R8", int'(ofs), ramp(m_cfg, m_t));
         else if (m_t == 0)     chk("R4", int'(ofs), ramp(m_cfg, m_t));
         else if (m_t == rl)    chk("R3", int'(ofs), peak_raw(m_cfg));
         else if (m_t < rl)     chk("R6", int'(ofs), ramp(m_cfg, m_t));
         else                   chk("R7", int'(ofs), ramp(m_cfg, m_t));
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_now();
   endtask

   initial begin
      // Reset state (R1, R2)
      repeat (3) @(negedge clk);
      chk("R1", int'(ofs), 0);
      chk("R2", int'(act), 0);
      rst_n = 1'b1;
      repeat (5) tick();

      // Sweep every code over two full periods plus an odd tail (R3-R8)
      for (int c = 1; c <= 15; c++) begin
         code_drv = 4'(c);
         for (int n = 0; n < 2 * div_of(c) + 37; n++) tick();
      end

      // Turn off, then an abrupt stop in the middle of a ramp (R1, R5)
      code_drv = 4'd0;
      repeat (4) tick();
      code_drv = 4'd6;
      repeat (50) tick();
      code_drv = 4'd0;
      tick();
      code_drv = 4'd6;
      repeat (20) tick();

      // Several code changes within one period: the last one wins (R8)
      code_drv = 4'd2;
      repeat (100) tick();
      code_drv = 4'd7;
      repeat (60) tick();
      code_drv = 4'd11;
      repeat (900) tick();

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

endmodule